// File: doc/BRIEF.md
# GPIO Pad Bias and Drive Configuration Registers

This block holds the pad settings of one bank of general-purpose pins (32 by default). For every pin it stores whether a bias resistor is connected and which way it pulls. It also stores a three-bit drive-strength code, kept in three bit-plane words: word *i* holds bit *i* of the code for every pin, and bit *p* of each word belongs to pin *p*. Software reaches the registers over a simple single-cycle register bus. The block drives per-pin pull-up, pull-down and drive-code outputs toward the pad cells.

Two build-time parameters let the block serve different controller variants. The first is the bias layout. In the default layout, one word holds the pull direction and another holds the resistor enable. In the split layout, one word holds the pull-up requests and another holds the pull-down requests. The second parameter sets the order of the bit-plane words: they either ascend from a base address with the code bit, or run backwards so that the most significant code bit sits in the lowest word. The drive code represents a current of (code+1)×2 mA, so software writes code = mA/2 − 1 for an even request from 2 to 16 mA.

All pad outputs and the read data are registered. A write lands in the register file on the edge that samples it, and the pad outputs show the effect one edge later.

Top module: `gpio_padcfg`

## Requirements
- R1: After a synchronous reset, every register reads 0, no pin has a pull-up or pull-down, every drive code is 0 (2 mA), and the read data is 0.
- R2: In the default bias layout, the pull-direction word is at byte address 0x34 (1 = up, 0 = down) and the pull-enable word is at 0x38 (1 = resistor on); each reads back at its write address.
- R3: In the default layout, pin p pulls up when enable and direction bits are both 1, and pulls down when enable is 1 and direction is 0; the outputs reflect a write on the second rising edge after the write is sampled.
- R4: Clearing a pin's enable bit releases both pulls on that pin and leaves its direction bit unchanged in readback.
- R5: In the split layout, pull-up requests are at 0x14 and pull-down requests at 0x10; a pin with only its up bit set pulls up, only its down bit set pulls down, and both or neither set drives no pull.
- R6: Bit i of pin p's drive code (output bits [3p+i]) equals bit p of plane word i; in ascending order, plane i is at DRV_BASE + 4·i (0x58, 0x5C, 0x60 by default), and each plane reads back at its address.
- R7: In reversed order, plane i is at DRV_BASE + 4·(2 − i), so the most significant code bit lives in the lowest of the three words.
- R8: A code written as mA/2 − 1 for any even request from 2 to 16 mA appears unchanged on the pin's drive-code output and decodes back as (code+1)·2 mA to the same request.
- R9: Read data appears on the edge after a read is sampled and holds until the next read; reads of unmapped or non-word-aligned addresses return 0, and writes to them change no register and no output.
- R10: No pin ever has its pull-up and pull-down outputs asserted at the same time.
- R11: A read and a write to the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata | output | NUM_PINS | Registered read data |
| pad_pull_up | output | NUM_PINS | Per-pin pull-up request to the pad |
| pad_pull_dn | output | NUM_PINS | Per-pin pull-down request to the pad |
| pad_drv_code | output | 3·NUM_PINS | Drive code per pin, pin p at bits [3p+2:3p] |

## Verification
The bench builds two instances: the default layout with ascending planes, and the split layout with reversed planes and base 0. If the plane order were swapped, the code bits would appear mirrored, so a write to the lowest word would show up in the code's least significant bit instead of its most significant bit. If enable were taken as the pull itself, or if clearing enable also cleared direction, the release check and the direction readback would catch it. In the split layout, a design that lets one side win when both bits are set would drive a pull where none is expected. A design that decodes only some of the address bits would alias a write aimed at an unmapped or misaligned address onto a real register. Same-cycle read and write, held read data, and every even milliamp request are exercised directly, and random writes against a bench model make up the rest.

// File: rtl/gpio_padcfg_pkg.sv
`timescale 1ns/1ps
package gpio_padcfg_pkg;

  localparam int unsigned DRV_BITS  = 3;
  localparam int unsigned NUM_SLOTS = 5;

  // Offsets of the bias words for each layout
  localparam int unsigned OFF_DIR   = 32'h34;
  localparam int unsigned OFF_EN    = 32'h38;
  localparam int unsigned OFF_UP    = 32'h14;
  localparam int unsigned OFF_DN    = 32'h10;

  typedef enum logic [2:0] {
    SLOT_BIAS_A = 3'd0,   // direction (default) or pull-up (split)
    SLOT_BIAS_B = 3'd1,   // enable (default) or pull-down (split)
    SLOT_PLANE0 = 3'd2,
    SLOT_PLANE1 = 3'd3,
    SLOT_PLANE2 = 3'd4
  } slot_e;

  typedef struct packed {
    logic  hit;
    slot_e slot;
  } dec_t;

  // Byte address of plane word i
  function automatic int unsigned plane_addr(input int unsigned base,
                                             input bit rev,
                                             input int unsigned i);
    return base + 4 * (rev ? (DRV_BITS - 1 - i) : i);
  endfunction

  // Map a byte address to a register slot; bias words take priority
  function automatic dec_t decode(input int unsigned a,
                                  input bit split,
                                  input bit rev,
                                  input int unsigned base);
    dec_t d;
    d.hit  = 1'b0;
    d.slot = SLOT_BIAS_A;
    if (a == (split ? OFF_UP : OFF_DIR)) begin
      d.hit  = 1'b1;
      d.slot = SLOT_BIAS_A;
    end else if (a == (split ? OFF_DN : OFF_EN)) begin
      d.hit  = 1'b1;
      d.slot = SLOT_BIAS_B;
    end else begin
      for (int unsigned i = 0; i < DRV_BITS; i++) begin
        if (a == plane_addr(base, rev, i)) begin
          d.hit  = 1'b1;
          d.slot = slot_e'(3'(int'(SLOT_PLANE0) + int'(i)));
        end
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/padcfg_regfile.sv
`timescale 1ns/1ps
module padcfg_regfile
  import gpio_padcfg_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          SPLIT_PULL = 1'b0,
  parameter bit          PLANE_REV  = 1'b0,
  parameter int unsigned DRV_BASE   = 32'h58
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [NUM_PINS-1:0]                  wdata,
  output logic [NUM_SLOTS-1:0][NUM_PINS-1:0]   words
);

  localparam int unsigned PAD_W = 32 - ADDR_W;

  dec_t dec;
  always_comb dec = decode({{PAD_W{1'b0}}, addr}, SPLIT_PULL, PLANE_REV, DRV_BASE);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic sel;
    assign sel = wr && dec.hit && (dec.slot == slot_e'(3'(s)));
    always_ff @(posedge clk) begin
      if (rst)
        words[s] <= '0;
      else if (sel)
        words[s] <= wdata;
    end
  end

endmodule

// File: rtl/padcfg_readmux.sv
`timescale 1ns/1ps
module padcfg_readmux
  import gpio_padcfg_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          SPLIT_PULL = 1'b0,
  parameter bit          PLANE_REV  = 1'b0,
  parameter int unsigned DRV_BASE   = 32'h58
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 rd,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [NUM_SLOTS-1:0][NUM_PINS-1:0]   words,
  output logic [NUM_PINS-1:0]                  rdata
);

  localparam int unsigned PAD_W = 32 - ADDR_W;

  dec_t                dec;
  logic [NUM_PINS-1:0] sel_word;

  always_comb begin
    dec      = decode({{PAD_W{1'b0}}, addr}, SPLIT_PULL, PLANE_REV, DRV_BASE);
    sel_word = '0;
    for (int unsigned s = 0; s < NUM_SLOTS; s++)
      if (dec.hit && (dec.slot == slot_e'(3'(s))))
        sel_word = words[s];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= sel_word;
  end

endmodule

// File: rtl/padcfg_pad_drive.sv
`timescale 1ns/1ps
module padcfg_pad_drive
  import gpio_padcfg_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter bit          SPLIT_PULL = 1'b0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PINS-1:0]                 bias_a,
  input  logic [NUM_PINS-1:0]                 bias_b,
  input  logic [DRV_BITS-1:0][NUM_PINS-1:0]   planes,
  output logic [NUM_PINS-1:0]                 pull_up,
  output logic [NUM_PINS-1:0]                 pull_dn,
  output logic [NUM_PINS*DRV_BITS-1:0]        drv_code
);

  logic [NUM_PINS-1:0]          up_n;
  logic [NUM_PINS-1:0]          dn_n;
  logic [NUM_PINS*DRV_BITS-1:0] code_n;

  if (SPLIT_PULL) begin : g_split
    // bias_a = up request, bias_b = down request; conflict drives neither
    assign up_n = bias_a & ~bias_b;
    assign dn_n = bias_b & ~bias_a;
  end else begin : g_dir_en
    // bias_a = direction, bias_b = enable
    assign up_n = bias_b &  bias_a;
    assign dn_n = bias_b & ~bias_a;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    for (genvar i = 0; i < DRV_BITS; i++) begin : g_bit
      assign code_n[p*DRV_BITS + i] = planes[i][p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_up  <= '0;
      pull_dn  <= '0;
      drv_code <= '0;
    end else begin
      pull_up  <= up_n;
      pull_dn  <= dn_n;
      drv_code <= code_n;
    end
  end

endmodule

// File: rtl/gpio_padcfg.sv
`timescale 1ns/1ps
module gpio_padcfg
  import gpio_padcfg_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          SPLIT_PULL = 1'b0,
  parameter bit          PLANE_REV  = 1'b0,
  parameter int unsigned DRV_BASE   = 32'h58
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_PINS-1:0]           bus_wdata,
  output logic [NUM_PINS-1:0]           bus_rdata,
  output logic [NUM_PINS-1:0]           pad_pull_up,
  output logic [NUM_PINS-1:0]           pad_pull_dn,
  output logic [NUM_PINS*DRV_BITS-1:0]  pad_drv_code
);

  logic [NUM_SLOTS-1:0][NUM_PINS-1:0] words;
  logic [DRV_BITS-1:0][NUM_PINS-1:0]  planes;

  for (genvar i = 0; i < DRV_BITS; i++) begin : g_plane
    assign planes[i] = words[int'(SLOT_PLANE0) + i];
  end

  padcfg_regfile #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .SPLIT_PULL(SPLIT_PULL),
    .PLANE_REV(PLANE_REV), .DRV_BASE(DRV_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .words(words)
  );

  padcfg_readmux #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .SPLIT_PULL(SPLIT_PULL),
    .PLANE_REV(PLANE_REV), .DRV_BASE(DRV_BASE)
  ) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .words(words), .rdata(bus_rdata)
  );

  padcfg_pad_drive #(
    .NUM_PINS(NUM_PINS), .SPLIT_PULL(SPLIT_PULL)
  ) u_pad (
    .clk(clk), .rst(rst),
    .bias_a(words[SLOT_BIAS_A]), .bias_b(words[SLOT_BIAS_B]),
    .planes(planes),
    .pull_up(pad_pull_up), .pull_dn(pad_pull_dn), .drv_code(pad_drv_code)
  );

endmodule

// File: rtl/gpio_padcfg_chk.sv
`timescale 1ns/1ps
module gpio_padcfg_chk
  import gpio_padcfg_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          SPLIT_PULL = 1'b0,
  parameter bit          PLANE_REV  = 1'b0,
  parameter int unsigned DRV_BASE   = 32'h58
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_wr,
  input logic                          bus_rd,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [NUM_PINS-1:0]           bus_wdata,
  input logic [NUM_PINS-1:0]           bus_rdata,
  input logic [NUM_PINS-1:0]           pad_pull_up,
  input logic [NUM_PINS-1:0]           pad_pull_dn,
  input logic [NUM_PINS*DRV_BITS-1:0]  pad_drv_code
);

  localparam int unsigned PL0_ADDR = DRV_BASE + 4 * (PLANE_REV ? (DRV_BITS - 1) : 0);

  // Two-stage record of writes to plane 0
  logic                s1, s2;
  logic [NUM_PINS-1:0] d1, d2;
  logic [NUM_PINS-1:0] code_b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; d1 <= '0; d2 <= '0;
    end else begin
      s1 <= bus_wr && (32'(bus_addr) == PL0_ADDR);
      d1 <= bus_wdata;
      s2 <= s1;
      d2 <= d1;
    end
  end

  always_comb
    for (int p = 0; p < NUM_PINS; p++)
      code_b0[p] = pad_drv_code[p*DRV_BITS];

  p_pulls_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_up & pad_pull_dn) == '0);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_pull_up == '0 && pad_pull_dn == '0 &&
                    pad_drv_code == '0 && bus_rdata == '0));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

  p_misaligned_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

  p_plane0_lsb_r6: assert property (@(posedge clk) disable iff (rst)
    s2 |-> code_b0 == d2);

endmodule

bind gpio_padcfg gpio_padcfg_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .SPLIT_PULL(SPLIT_PULL),
  .PLANE_REV(PLANE_REV), .DRV_BASE(DRV_BASE)
) u_chk (.*);

// File: tb/test_gpio_padcfg.sv
`timescale 1ns/1ps
module test_gpio_padcfg;

  localparam int NP = 32;
  localparam int CW = NP * 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          wr_a = 0, wr_b = 0, rd = 0;
  logic [7:0]    addr = '0;
  logic [NP-1:0] wdata = '0;
  logic [NP-1:0] rdata_a, rdata_b, up_a, dn_a, up_b, dn_b;
  logic [CW-1:0] code_a, code_b;

  int n_tests = 0;
  int n_fail  = 0;

  gpio_padcfg i_gpio_padcfg (
    .clk(clk), .rst(rst), .bus_wr(wr_a), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .pad_pull_up(up_a),
    .pad_pull_dn(dn_a), .pad_drv_code(code_a));

  gpio_padcfg #(.SPLIT_PULL(1'b1), .PLANE_REV(1'b1), .DRV_BASE(0)) i_gpio_padcfg_alt (
    .clk(clk), .rst(rst), .bus_wr(wr_b), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .pad_pull_up(up_b),
    .pad_pull_dn(dn_b), .pad_drv_code(code_b));

  // Bench model
  logic [NP-1:0] a_dir = '0, a_en = '0, b_up = '0, b_dn = '0;
  logic [NP-1:0] a_pl [3];
  logic [NP-1:0] b_pl [3];

  function automatic logic [CW-1:0] mk_code(input logic [NP-1:0] p0, p1, p2);
    logic [CW-1:0] c;
    for (int p = 0; p < NP; p++) c[p*3 +: 3] = {p2[p], p1[p], p0[p]};
    return c;
  endfunction

  function automatic int ma_to_code(input int ma); return ma / 2 - 1; endfunction
  function automatic int code_to_ma(input int c);  return (c + 1) * 2; endfunction

  function automatic logic [7:0] a_addr(input int k);
    case (k)
      0: return 8'h34; 1: return 8'h38;
      default: return 8'(8'h58 + 4 * (k - 2));
    endcase
  endfunction

  function automatic logic [7:0] b_addr(input int k);
    case (k)
      0: return 8'h14; 1: return 8'h10;
      default: return 8'(4 * (2 - (k - 2)));
    endcase
  endfunction

  task automatic check(input logic [CW-1:0] act, exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write(input bit to_b, input logic [7:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (to_b) wr_b = 1; else wr_a = 1;
    @(negedge clk);
    wr_a = 0; wr_b = 0;
    for (int k = 0; k < 5; k++) begin
      if (!to_b && a == a_addr(k)) begin
        if (k == 0) a_dir = d; else if (k == 1) a_en = d; else a_pl[k-2] = d;
      end
      if (to_b && a == b_addr(k)) begin
        if (k == 0) b_up = d; else if (k == 1) b_dn = d; else b_pl[k-2] = d;
      end
    end
  endtask

  task automatic read_chk(input bit of_b, input logic [7:0] a,
                          input logic [NP-1:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0;
    check(CW'(of_b ? rdata_b : rdata_a), CW'(exp), tag);
  endtask

  task automatic settle; @(negedge clk); endtask

  task automatic check_outputs(input string tag);
    check(CW'(up_a), CW'(a_en & a_dir),  {tag, " A up"});
    check(CW'(dn_a), CW'(a_en & ~a_dir), {tag, " A dn"});
    check(code_a, mk_code(a_pl[0], a_pl[1], a_pl[2]), {tag, " A code"});
    check(CW'(up_b), CW'(b_up & ~b_dn),  {tag, " B up"});
    check(CW'(dn_b), CW'(b_dn & ~b_up),  {tag, " B dn"});
    check(code_b, mk_code(b_pl[0], b_pl[1], b_pl[2]), {tag, " B code"});
    check(CW'(up_a & dn_a | up_b & dn_b), '0, "R10 exclusive pulls");
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin a_pl[i] = '0; b_pl[i] = '0; end
    void'($urandom(32'd7103));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check(CW'(up_a | dn_a | up_b | dn_b), '0, "R1 pulls after reset");
    check(code_a | code_b, '0, "R1 code after reset");
    check(CW'(rdata_a | rdata_b), '0, "R1 rdata after reset");
    for (int k = 0; k < 5; k++) begin
      read_chk(0, a_addr(k), '0, "R1 reg A zero");
      read_chk(1, b_addr(k), '0, "R1 reg B zero");
    end

    // R2 / R3 default layout
    write(0, 8'h34, 32'hA5A5_0F0F);
    write(0, 8'h38, 32'hFFFF_0000);
    settle();
    check_outputs("R3 dir/en pulls");
    read_chk(0, 8'h34, 32'hA5A5_0F0F, "R2 dir readback");
    read_chk(0, 8'h38, 32'hFFFF_0000, "R2 en readback");

    // R4 release keeps direction
    write(0, 8'h38, 32'h0000_0000);
    settle();
    check(CW'(up_a | dn_a), '0, "R4 pulls released");
    read_chk(0, 8'h34, 32'hA5A5_0F0F, "R4 dir kept");

    // R6 ascending planes
    write(0, 8'h58, 32'h1234_5678);
    write(0, 8'h5C, 32'hF0F0_F0F0);
    write(0, 8'h60, 32'h8000_0001);
    settle();
    check_outputs("R6 ascending planes");
    read_chk(0, 8'h5C, 32'hF0F0_F0F0, "R6 plane1 readback");

    // R7 reversed planes: the lowest word is the top code bit
    write(1, 8'h00, 32'h0000_0001);
    settle();
    check(CW'(code_b[2:0]), CW'(3'b100), "R7 low word is msb");
    write(1, 8'h08, 32'h0000_0003);
    settle();
    check_outputs("R7 reversed planes");

    // R5 split layout, conflicts drive neither
    write(1, 8'h14, 32'h0000_FFFF);
    write(1, 8'h10, 32'h00FF_00FF);
    settle();
    check_outputs("R5 split pulls");
    check(CW'(up_b[0] | dn_b[0]), '0, "R5 both set gives none");
    read_chk(1, 8'h10, 32'h00FF_00FF, "R5 down readback");

    // R8 every even milliamp request on pin 5
    for (int ma = 2; ma <= 16; ma += 2) begin
      int c;
      c = ma_to_code(ma);
      for (int i = 0; i < 3; i++) write(0, a_addr(2 + i), NP'(((c >> i) & 1) << 5));
      settle();
      check(CW'(code_a[15 +: 3]), CW'(c), "R8 code for mA");
      check(CW'(code_to_ma(int'(code_a[15 +: 3]))), CW'(ma), "R8 decoded mA");
    end

    // R9 unmapped / misaligned / hold
    read_chk(0, 8'h3C, '0, "R9 unmapped read");
    read_chk(0, 8'h35, '0, "R9 misaligned read");
    write(0, 8'h3C, 32'hFFFF_FFFF);
    write(0, 8'h59, 32'hFFFF_FFFF);
    write(1, 8'h0C, 32'hFFFF_FFFF);
    settle();
    check_outputs("R9 stray writes ignored");
    for (int k = 0; k < 5; k++) read_chk(0, a_addr(k), (k == 0) ? a_dir : (k == 1) ? a_en : a_pl[k-2], "R9 regs intact");
    read_chk(0, 8'h34, a_dir, "R9 read before hold");
    write(0, 8'h38, 32'h5555_5555);
    repeat (3) settle();
    check(CW'(rdata_a), CW'(a_dir), "R9 rdata holds");

    // R11 same-cycle read and write
    @(negedge clk);
    addr = 8'h34; wdata = 32'h0BAD_F00D; wr_a = 1; rd = 1;
    @(negedge clk);
    wr_a = 0; rd = 0;
    check(CW'(rdata_a), CW'(a_dir), "R11 read returns old value");
    a_dir = 32'h0BAD_F00D;
    read_chk(0, 8'h34, 32'h0BAD_F00D, "R11 new value after");

    // Random mix against the model
    for (int it = 0; it < 40; it++) begin
      write(0, a_addr(int'($urandom % 5)), $urandom);
      write(1, b_addr(int'($urandom % 5)), $urandom);
      settle();
      check_outputs("R3 R5 R6 R7 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule